// File: doc/BRIEF.md
# Fast A20 Gate and Reset Control Port

This block is a single eight-bit control register on a byte-wide ISA-style I/O bus. It answers at one I/O address, which defaults to 0x92. A write that hits the address stores the whole byte. A read that hits the address returns the stored byte unchanged.

Two bits of the register have a function. The gate bit (bit 1) drives the A20 gate output level for as long as the value is held. When a write sets the request bit (bit 0) to one, the block issues a system reset request to the reset sequencer, which sits outside this block.

There are two reset inputs. The power-on reset clears the whole register. The warm reset clears only the request bit, so the A20 setting and the other six bits survive a system reset. The bus side has no back-pressure. Every access completes in the cycle it is presented: the write strobe, the read strobe, the address and the data are sampled on each rising clock edge. Read data is combinational, which is why no valid/ready handshake is used.

Top module: `fast_gate_ctl`

## Requirements
- R1: The register responds only when the full 16-bit address equals 0x0092. A write is accepted only when `io_wr` is high, and read data is returned only when `io_rd` is high.
- R2: An accepted write stores all eight bits of `io_wdata` at the clock edge. From then on, a hit read returns that byte on `io_rdata`, with bit 7 as the most significant bit.
- R3: `gate_a20` always equals bit 1 of the stored value. It changes in the cycle after the write that changes that bit and stays at that level until the bit changes again.
- R4: An accepted write with bit 0 of the data equal to one raises `sys_rst_req` for exactly one cycle, in the cycle after the write. A write with bit 0 equal to zero raises no request. Holding bit 0 at one in the register does not hold the request high. Consecutive writes with bit 0 set give consecutive pulses.
- R5: While `warm_rst` is high and `por_n` is high, bit 0 of the register is cleared at each clock edge and bits 7..1 keep their values.
- R6: While `por_n` is low, the register is cleared to 0x00 at each clock edge and no request is issued. This takes priority over the warm reset and over any write.
- R7: A write presented in a cycle in which `warm_rst` is high is dropped. It stores nothing and raises no request.
- R8: An access to any other address leaves the register unchanged. When no hit read is present, `io_rdata` is 0x00 and `io_rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all bits |
| warm_rst | input | 1 | Warm (system) reset, active high; clears bit 0 only |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, stored byte on a hit read, else 0x00 |
| io_rdata_oe | output | 1 | High when this block drives the read data bus |
| gate_a20 | output | 1 | A20 gate level, bit 1 of the stored byte |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench targets the places where the two reset inputs and the write path interact.

- **Warm reset that clears too much.** The bench applies a warm reset after writing a byte with the gate bit and upper bits set. A design that clears the whole byte loses the A20 level and the upper bits.
- **Write colliding with warm reset.** A write that arrives during a warm reset would store data or fire a request in a design that lets the write through.
- **Request held as a level.** Single writes and back-to-back writes with bit 0 set separate a true one-cycle pulse from a level that follows the stored bit.
- **Loose address decode.** Writes to a neighbouring address and to an address that differs only in the upper bits catch a design that decodes too few address bits or that drives the read bus when the access is not a hit.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  localparam int unsigned FGC_ADDR_W   = 16;
  localparam int unsigned FGC_DATA_W   = 8;
  localparam logic [FGC_ADDR_W-1:0] FGC_PORT_ADDR = 16'h0092;
  localparam int unsigned FGC_GATE_BIT = 1;
  localparam int unsigned FGC_REQ_BIT  = 0;
endpackage

// File: rtl/fgc_addr_match.sv
module fgc_addr_match #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic sel;

  always_comb begin
    sel    = (addr == PORT_ADDR);
    wr_hit = sel && wr;
    rd_hit = sel && rd;
  end
endmodule

// File: rtl/fgc_ctl_reg.sv
module fgc_ctl_reg #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned REQ_BIT = 0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << REQ_BIT);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == REQ_BIT) begin : g_req
      always_ff @(posedge clk) begin
        if (!por_n)        q[b] <= 1'b0;
        else if (warm_rst) q[b] <= 1'b0;
        else if (wr_en)    q[b] <= wdata[b];
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (!por_n)                   q[b] <= 1'b0;
        else if (wr_en && !warm_rst)  q[b] <= wdata[b];
      end
    end
  end

  // R5: warm reset clears only the request bit
  a_r5_warm_keeps_upper: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |=> ((q & KEEP_MASK) == ($past(q) & KEEP_MASK)) && !q[REQ_BIT]);

  // R7: write during warm reset stores nothing
  a_r7_warm_blocks_write: assert property (@(posedge clk) disable iff (!por_n)
    (warm_rst && wr_en) |=> ((q & KEEP_MASK) == ($past(q) & KEEP_MASK)));
endmodule

// File: rtl/fgc_req_pulse.sv
module fgc_req_pulse (
  input  logic clk,
  input  logic por_n,
  input  logic warm_rst,
  input  logic fire,
  output logic req
);
  always_ff @(posedge clk) begin
    if (!por_n) req <= 1'b0;
    else        req <= fire && !warm_rst;
  end

  // R4: a pulse is followed by low unless a new firing write came
  a_r4_pulse_not_level: assert property (@(posedge clk) disable iff (!por_n)
    (req && !fire) |=> !req);
endmodule

// File: rtl/fast_gate_ctl.sv
module fast_gate_ctl
  import fgc_pkg::*;
#(
  parameter int unsigned ADDR_W    = FGC_ADDR_W,
  parameter int unsigned DATA_W    = FGC_DATA_W,
  parameter logic [ADDR_W-1:0] PORT_ADDR = FGC_PORT_ADDR,
  parameter int unsigned GATE_BIT  = FGC_GATE_BIT,
  parameter int unsigned REQ_BIT   = FGC_REQ_BIT
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rdata_oe,
  output logic              gate_a20,
  output logic              sys_rst_req
);
  logic              wr_hit;
  logic              rd_hit;
  logic [DATA_W-1:0] ctl_q;

  fgc_addr_match #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_match (
    .addr   (io_addr),
    .wr     (io_wr),
    .rd     (io_rd),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  fgc_ctl_reg #(.DATA_W(DATA_W), .REQ_BIT(REQ_BIT)) u_reg (
    .clk      (clk),
    .por_n    (por_n),
    .warm_rst (warm_rst),
    .wr_en    (wr_hit),
    .wdata    (io_wdata),
    .q        (ctl_q)
  );

  fgc_req_pulse u_pulse (
    .clk      (clk),
    .por_n    (por_n),
    .warm_rst (warm_rst),
    .fire     (wr_hit && io_wdata[REQ_BIT]),
    .req      (sys_rst_req)
  );

  always_comb begin
    io_rdata    = rd_hit ? ctl_q : '0;
    io_rdata_oe = rd_hit;
    gate_a20    = ctl_q[GATE_BIT];
  end

  // R4: a request only follows an accepted write carrying bit 0 set
  a_r4_req_needs_write: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req |-> $past(io_wr && (io_addr == PORT_ADDR) && io_wdata[REQ_BIT] && !warm_rst));

  // R3: the gate only moves after a hit write or a power-on reset
  a_r3_gate_moves_on_write: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(gate_a20) |-> $past(io_wr && (io_addr == PORT_ADDR)) || $past(!por_n));

  // R8: a write elsewhere leaves the register untouched
  a_r8_other_addr_no_change: assert property (@(posedge clk) disable iff (!por_n)
    (io_wr && (io_addr != PORT_ADDR) && !warm_rst) |=> $stable(ctl_q));

  // R6: power-on reset clears everything and silences the request
  a_r6_por_clears: assert property (@(posedge clk)
    !por_n |=> (ctl_q == '0) && !sys_rst_req);

  // R8: the read bus is quiet unless a hit read is present
  a_r8_bus_quiet: assert property (@(posedge clk) disable iff (!por_n)
    !(io_rd && (io_addr == PORT_ADDR)) |-> (io_rdata == '0) && !io_rdata_oe);
endmodule

// File: tb/test_fast_gate_ctl.sv
module test_fast_gate_ctl;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        io_rdata_oe;
  logic        gate_a20;
  logic        sys_rst_req;

  int total = 0;
  int bad = 0;
  logic [7:0] m_reg = 8'h00;
  logic       m_req = 1'b0;
  logic       m_acc;
  logic [7:0] m_rd;

  always #10 clk = ~clk;

  fast_gate_ctl i_fast_gate_ctl (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rdata_oe(io_rdata_oe), .gate_a20(gate_a20), .sys_rst_req(sys_rst_req)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Reference model, stepped on every clock, compared 5 ns later
  always @(posedge clk) begin
    m_acc = por_n && !warm_rst && io_wr && (io_addr == 16'h0092);
    if (!por_n) begin
      m_reg = 8'h00;
      m_req = 1'b0;
    end else begin
      m_req = m_acc && io_wdata[0];
      if (warm_rst) m_reg[0] = 1'b0;
      else if (m_acc) m_reg = io_wdata;
    end
    #5;
    check("R3 gate level", {7'b0, gate_a20}, {7'b0, m_reg[1]});
    check("R4 request pulse", {7'b0, sys_rst_req}, {7'b0, m_req});
    m_rd = (io_rd && io_addr == 16'h0092) ? m_reg : 8'h00;
    check("R2/R8 read data", io_rdata, m_rd);
    check("R8 read enable", {7'b0, io_rdata_oe}, {7'b0, io_rd && io_addr == 16'h0092});
  end

  task automatic drive(input logic [15:0] a, input logic w, input logic r,
                       input logic [7:0] d, input logic wr_rst);
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d; warm_rst = wr_rst;
  endtask

  task automatic idle();
    drive(16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic read_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    drive(a, 1'b0, 1'b1, 8'h00, 1'b0);
    #2;
    check(tag, io_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    read_chk("R6 read during power-on reset", 16'h0092, 8'h00);
    @(negedge clk); por_n = 1'b1;
    read_chk("R6 reset value", 16'h0092, 8'h00);
    check("R6 gate after reset", {7'b0, gate_a20}, 8'h00);

    drive(16'h0092, 1'b1, 1'b0, 8'h02, 1'b0);
    idle(); #2;
    check("R3 gate set by write", {7'b0, gate_a20}, 8'h01);
    check("R4 no pulse when bit 0 clear", {7'b0, sys_rst_req}, 8'h00);
    read_chk("R2 stored byte", 16'h0092, 8'h02);

    drive(16'h0092, 1'b1, 1'b0, 8'hA7, 1'b0);
    idle(); #2;
    check("R4 pulse after write", {7'b0, sys_rst_req}, 8'h01);
    idle(); #2;
    check("R4 pulse not held", {7'b0, sys_rst_req}, 8'h00);
    read_chk("R2 full byte stored", 16'h0092, 8'hA7);

    drive(16'h0000, 1'b0, 1'b0, 8'h00, 1'b1);
    idle();
    read_chk("R5 warm reset clears bit 0 only", 16'h0092, 8'hA6);
    check("R5 gate kept", {7'b0, gate_a20}, 8'h01);

    drive(16'h0093, 1'b1, 1'b0, 8'h00, 1'b0);
    drive(16'h0192, 1'b1, 1'b0, 8'h01, 1'b0);
    idle(); #2;
    check("R1 no pulse for upper-bit mismatch", {7'b0, sys_rst_req}, 8'h00);
    read_chk("R8 other address no change", 16'h0092, 8'hA6);
    read_chk("R8 other address read quiet", 16'h0093, 8'h00);
    check("R8 no drive elsewhere", {7'b0, io_rdata_oe}, 8'h00);
    drive(16'h0092, 1'b0, 1'b0, 8'h00, 1'b0); #2;
    check("R1 no read strobe no data", io_rdata, 8'h00);

    drive(16'h0092, 1'b1, 1'b0, 8'h01, 1'b1);
    idle(); #2;
    check("R7 no pulse during warm reset", {7'b0, sys_rst_req}, 8'h00);
    read_chk("R7 write dropped", 16'h0092, 8'hA6);

    drive(16'h0092, 1'b1, 1'b0, 8'h01, 1'b0);
    drive(16'h0092, 1'b1, 1'b0, 8'h03, 1'b0); #2;
    check("R4 first back-to-back pulse", {7'b0, sys_rst_req}, 8'h01);
    idle(); #2;
    check("R4 second back-to-back pulse", {7'b0, sys_rst_req}, 8'h01);
    read_chk("R2 last write wins", 16'h0092, 8'h03);

    @(negedge clk);
    por_n = 1'b0; warm_rst = 1'b1; io_wr = 1'b1; io_rd = 1'b0;
    io_addr = 16'h0092; io_wdata = 8'h55;
    @(negedge clk); #2;
    check("R6 power-on reset priority", {7'b0, sys_rst_req}, 8'h00);
    check("R6 gate cleared", {7'b0, gate_a20}, 8'h00);
    idle(); por_n = 1'b1;
    read_chk("R6 register cleared", 16'h0092, 8'h00);
    idle(); idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule